// File: doc/BRIEF.md
# Two-Wire Bus Target with Write-Latch Acknowledge Control

This block is a target (responder) on a two-wire serial bus of the open-drain, I2C kind. The bus clock and data lines are oversampled in the system clock domain. The block finds start and stop conditions, compares the first byte of each transfer with its own identity, and then moves bytes into or out of a 256-byte internal register file. It never drives the data line high. It only asserts a pull-down enable, which the pad or the bench combines with the external pull-up as a wired AND.

The acknowledge decision depends on more than the address match. One bit of a protect register, the write-enable latch, must be set before ordinary registers accept data. The protect register itself is always writable, so that software can set the latch. A status register accepts a single data byte per transfer. Reads start at the current register pointer and advance it after each byte. They go on for as long as the initiator acknowledges.

Top module: `twire_slave`

## Requirements
- R1: After reset `sda_oe` is low, the FSM is idle, every register reads 0x00 and the write-enable latch is clear.
- R2: Until a start has been seen (SDA falling while SCL is high), bus activity is ignored: a correct address byte clocked in without a start is not acknowledged.
- R3: The first byte after a start is {ID[3:0], select[2:0], rw}, sent MSB first, where rw=1 selects a read. When ID equals `DEV_ID` and select equals `sel_i`, the block pulls SDA low during the ninth clock.
- R4: On an address mismatch SDA stays released, and the block ignores every following byte until the next start.
- R5: In a write, the byte after the address byte loads the register pointer and is always acknowledged. Each acknowledged data byte is stored at the pointer, which then increments.
- R6: The write-enable latch is bit 1 of the protect register at 0xFF. While it is 0, data bytes to any other address are not acknowledged and not stored. Writes to 0xFF are always acknowledged and stored.
- R7: Once a data byte has been written to the status register at 0x3F, every further data byte in the same transfer is not acknowledged and is discarded.
- R8: In a read, the block sends the byte at the pointer MSB first and increments the pointer. After each byte where the initiator acknowledges, it sends the next byte.
- R9: When the initiator does not acknowledge a read byte, the block stops driving SDA until the next stop or start.
- R10: A start that arrives in the middle of a transfer, even partway through a byte, restarts the address phase.
- R11: A stop ends any transfer, releases SDA and returns the block to idle. A write that is cut off before its data byte stores nothing.
- R12: `sda_oe` changes only while the synchronised SCL is low, except when a start or stop forces it off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sel_i | input | 3 | Select value compared with bits 3..1 of the address byte |
| sda_oe | output | 1 | Pull-down enable for SDA; 1 drives the line low |

## Verification
The address-phase restart and the acknowledge decision can meet on one SCL edge. A repeated start can arrive in the same bit window in which a data byte would otherwise finish and be stored. The bench provokes this by sending half a data byte and then issuing a start. It then requires that the new address byte is acknowledged and that the cut-off byte leaves no trace in the register file. A second collision comes from the write gate and the status-register limit, which both decide the ninth bit. The bench writes two bytes starting at 0x3F with the latch set and judges the acknowledge bits together with what a later read returns from 0x3F and 0x40.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK,
    S_WAIT
  } tw_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_REG,
    K_DATA
  } tw_kind_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign cond_start = scl_s & scl_q & sda_q & ~sda_s;
  assign cond_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] PROT_ADDR = '1,
  parameter int          WEL_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          wel
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
  assign wel   = mem_q[PROT_ADDR][WEL_BIT];
endmodule

// File: rtl/twire_slave.sv
module twire_slave
  import tw_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         AW          = 8,
  parameter logic [7:0] PROT_ADDR   = 8'hFF,
  parameter logic [7:0] STAT_ADDR   = 8'h3F,
  parameter int         WEL_BIT     = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_oe
);
  localparam int DW = 8;
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [1:0] sync_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, cond_start, cond_stop;

  tw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (sync_s)
  );
  assign scl_s = sync_s[1];
  assign sda_s = sync_s[0];

  tw_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .cond_start(cond_start),
    .cond_stop (cond_stop)
  );

  tw_state_e      state_q, state_d;
  tw_kind_e       kind_q, kind_d;
  logic [BW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic           oe_q, oe_d;
  logic           ack_q, ack_d;
  logic           half_q, half_d;
  logic           rw_q, rw_d;
  logic           lock_q, lock_d;
  logic           more_q, more_d;

  logic           mem_we;
  logic [DW-1:0]  rdata;
  logic           wel;
  logic [DW-1:0]  byte_in;
  logic           wr_ok;

  tw_regfile #(.AW(AW), .DW(DW), .PROT_ADDR(AW'(PROT_ADDR)), .WEL_BIT(WEL_BIT)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .addr (ptr_q),
    .wdata(byte_in),
    .rdata(rdata),
    .wel  (wel)
  );

  assign byte_in = {sh_q[DW-2:0], sda_s};
  assign wr_ok   = ~lock_q & (wel | (ptr_q == AW'(PROT_ADDR)));

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    ack_d   = ack_q;
    half_d  = half_q;
    rw_d    = rw_q;
    lock_d  = lock_q;
    more_d  = more_q;
    mem_we  = 1'b0;

    if (cond_stop) begin
      state_d = S_IDLE;
      oe_d    = 1'b0;
    end else if (cond_start) begin
      state_d = S_RX;
      kind_d  = K_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
      lock_d  = 1'b0;
      half_d  = 1'b0;
      more_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_RX: begin
          if (scl_rise) begin
            sh_d  = byte_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = S_ACK;
              half_d  = 1'b0;
              unique case (kind_q)
                K_DEV: begin
                  if (byte_in[7:4] == DEV_ID && byte_in[3:1] == sel_i) begin
                    ack_d = 1'b1;
                    rw_d  = byte_in[0];
                  end else begin
                    state_d = S_IDLE;
                  end
                end
                K_REG: begin
                  ack_d = 1'b1;
                  ptr_d = byte_in[AW-1:0];
                end
                default: begin
                  ack_d  = wr_ok;
                  mem_we = wr_ok;
                  if (wr_ok) begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == AW'(STAT_ADDR)) lock_d = 1'b1;
                  end
                end
              endcase
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (!half_q) begin
              oe_d   = ack_q;
              half_d = 1'b1;
            end else begin
              half_d = 1'b0;
              oe_d   = 1'b0;
              cnt_d  = '0;
              if (kind_q == K_DEV && rw_q) begin
                sh_d    = rdata;
                oe_d    = ~rdata[DW-1];
                ptr_d   = ptr_q + 1'b1;
                state_d = S_TX;
              end else begin
                state_d = S_RX;
                kind_d  = (kind_q == K_DEV) ? K_REG : K_DATA;
              end
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = S_MACK;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              oe_d  = ~sh_q[DW-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_s) state_d = S_WAIT;
            else       more_d  = 1'b1;
          end else if (scl_fall && more_q) begin
            more_d  = 1'b0;
            sh_d    = rdata;
            oe_d    = ~rdata[DW-1];
            ptr_d   = ptr_q + 1'b1;
            cnt_d   = '0;
            state_d = S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      half_q  <= 1'b0;
      rw_q    <= 1'b0;
      lock_q  <= 1'b0;
      more_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      ack_q   <= ack_d;
      half_q  <= half_d;
      rw_q    <= rw_d;
      lock_q  <= lock_d;
      more_q  <= more_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/tw_chk.sv
module tw_chk
  import tw_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [7:0]  PROT_ADDR = 8'hFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          start,
  input logic          stop,
  input tw_state_e     state,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic          wel
);
  assert_oe_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(start) && !$past(stop)) |-> !scl_s);

  assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_oe));

  assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_RX));

  assert_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wel || waddr == AW'(PROT_ADDR)));
endmodule

bind twire_slave tw_chk #(.AW(AW), .PROT_ADDR(PROT_ADDR)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sda_oe(sda_oe),
  .scl_s (scl_s),
  .start (cond_start),
  .stop  (cond_stop),
  .state (state_q),
  .we    (mem_we),
  .waddr (ptr_q),
  .wel   (wel)
);

// File: tb/test_twire_slave.sv
module test_twire_slave;
  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_sda;
  logic [2:0] sel;
  logic       sda_oe;
  logic       sda_bus;

  int nchk;
  int nfail;

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  // {is_read, reg address, data, expected (ack bit for writes, byte for reads)}
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'hFF, 8'h02, 8'h01},
    {1'b0, 8'h10, 8'hA5, 8'h01},
    {1'b1, 8'h10, 8'h00, 8'hA5},
    {1'b0, 8'hFF, 8'h00, 8'h01},
    {1'b0, 8'h11, 8'h3C, 8'h00},
    {1'b1, 8'h11, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'h02, 8'h01},
    {1'b0, 8'h20, 8'h5A, 8'h01},
    {1'b1, 8'h20, 8'h00, 8'h5A}
  };

  assign sda_bus = m_sda & ~sda_oe;

  twire_slave i_twire_slave (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl),
    .sda_i (sda_bus),
    .sel_i (sel),
    .sda_oe(sda_oe)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt();
    scl = 1'b1;   wt();
    m_sda = 1'b0; wt();
    scl = 1'b0;   wt();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt();
    scl = 1'b1;   wt();
    m_sda = 1'b1; wt();
  endtask

  task automatic tx_bit(input logic b);
    m_sda = b; wt();
    scl = 1'b1; wt();
    scl = 1'b0; wt();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    m_sda = 1'b1; wt();
    scl = 1'b1; wt();
    ack = ~sda_bus;
    scl = 1'b0; wt();
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt();
      scl = 1'b1; wt();
      b[i] = sda_bus;
      scl = 1'b0;
    end
    wt();
    m_sda = ~mack; wt();
    scl = 1'b1; wt();
    scl = 1'b0; wt();
    m_sda = 1'b1;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, output logic ack);
    logic k;
    bus_start();
    tx_byte(DEV_W, k);
    tx_byte(a, k);
    tx_byte(d, ack);
    bus_stop();
  endtask

  task automatic rd_open(input logic [7:0] a);
    logic k;
    bus_start();
    tx_byte(DEV_W, k);
    tx_byte(a, k);
    bus_start();
    tx_byte(DEV_R, k);
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    rd_open(a);
    rx_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    nchk = 0; nfail = 0;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; sel = 3'b101;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wt();

    // Reset state
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);
    wr1(8'h05, 8'h77, ack);
    chk("R1 latch clear after reset", {7'd0, ack}, 8'h00);
    rd1(8'h05, d);
    chk("R1 register zero after reset", d, 8'h00);

    // Vector table (R5, R6, R8)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) begin
        rd1(VEC[v][23:16], d);
        chk("R8 R6 vector read", d, VEC[v][7:0]);
      end else begin
        wr1(VEC[v][23:16], VEC[v][15:8], ack);
        chk("R5 R6 vector write ack", {7'd0, ack}, VEC[v][7:0]);
      end
    end

    // R5 multi-byte write with auto-increment
    bus_start();
    tx_byte(DEV_W, ack); chk("R3 address ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h40, ack); chk("R5 reg address ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h11, ack); chk("R5 data0 ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h22, ack); chk("R5 data1 ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h33, ack); chk("R5 data2 ack", {7'd0, ack}, 8'h01);
    bus_stop();

    // R8 / R9 sequential read, nack ends transmission
    rd_open(8'h40);
    rx_byte(1'b1, d); chk("R8 read byte0", d, 8'h11);
    rx_byte(1'b1, d); chk("R8 read byte1", d, 8'h22);
    rx_byte(1'b0, d); chk("R8 read byte2", d, 8'h33);
    rx_byte(1'b0, d); chk("R9 silent after nack", d, 8'hFF);
    bus_stop();
    chk("R11 released after stop", {7'd0, sda_oe}, 8'h00);

    // R7 status register takes one byte
    bus_start();
    tx_byte(DEV_W, ack);
    tx_byte(8'h3F, ack);
    tx_byte(8'hC3, ack); chk("R7 first status byte ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h7E, ack); chk("R7 second status byte nack", {7'd0, ack}, 8'h00);
    bus_stop();
    rd_open(8'h3F);
    rx_byte(1'b1, d); chk("R7 status value", d, 8'hC3);
    rx_byte(1'b0, d); chk("R7 next register untouched", d, 8'h11);
    bus_stop();

    // R4 mismatches
    bus_start();
    tx_byte(8'h5A, ack); chk("R4 wrong id nack", {7'd0, ack}, 8'h00);
    tx_byte(DEV_W, ack); chk("R4 ignored until start", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start();
    tx_byte(8'hA8, ack); chk("R4 wrong select nack", {7'd0, ack}, 8'h00);
    bus_stop();
    sel = 3'b100;
    bus_start();
    tx_byte(8'hA8, ack); chk("R3 select follows pins", {7'd0, ack}, 8'h01);
    bus_stop();
    sel = 3'b101;

    // R2 no start
    tx_byte(DEV_W, ack); chk("R2 no ack without start", {7'd0, ack}, 8'h00);
    bus_stop();

    // R10 repeated start mid-byte
    bus_start();
    tx_byte(DEV_W, ack);
    tx_byte(8'h60, ack);
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1); tx_bit(1'b1);
    bus_start();
    tx_byte(DEV_W, ack); chk("R10 restart address ack", {7'd0, ack}, 8'h01);
    tx_byte(8'h61, ack);
    tx_byte(8'h99, ack); chk("R10 data after restart", {7'd0, ack}, 8'h01);
    bus_stop();
    rd1(8'h61, d); chk("R10 written value", d, 8'h99);
    rd1(8'h60, d); chk("R10 cut byte not stored", d, 8'h00);

    // R11 stop cuts a write
    bus_start();
    tx_byte(DEV_W, ack);
    tx_byte(8'h70, ack);
    bus_stop();
    tx_byte(8'hAA, ack); chk("R11 idle after stop", {7'd0, ack}, 8'h00);
    bus_stop();
    rd1(8'h70, d); chk("R11 nothing stored", d, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule